// File: doc/BRIEF.md
# Programmable Watchdog Timer

This block watches a system for signs of life. Software programs one byte that gives a timeout as a 5-bit multiplier scaled by a power of four. The count runs in steps of a 16 Hz tick enable that is supplied from outside, so one step is a sixteenth of a second. Software keeps the watchdog from expiring in one of two ways: it rewrites the setting byte, or it reads the status byte.

When the count runs out, a sticky expiry flag is set. A steering bit in the setting byte then chooses the action. With the bit clear, the block gives a one-cycle interrupt pulse. With the bit set, it gives a one-cycle reset request, wipes its own setting byte to zero (which leaves it idle) and clears a neighbouring control bit kept in a third register. The expiry flag stays set through that action, so software can tell after restart why the reset happened.

Access is through a simple byte register bus: write strobe, read strobe, a 2-bit address and combinational read data. A setting of zero for the multiplier disables the watchdog.

Top module: `wdog_core`

## Requirements
- R1: Setting byte (address 0): bits 1:0 are the resolution r, bits 6:2 are the multiplier m, bit 7 is the steering bit (1 = reset request, 0 = interrupt). The timeout is m * 4^r ticks. Address 0 reads back the byte last written.
- R2: A write to address 0 stores the byte, clears the expiry flag and restarts the count from the new timeout.
- R3: A read of address 1 (status) returns the expiry flag in bit 7 with all other bits 0, and restarts the count from the timeout of the stored setting. The flag itself is left unchanged by the read.
- R4: After a restart with timeout N ≥ 1, the count expires on the N-th tick enable. Its outputs appear in the cycle after the clock edge that samples that tick, and never earlier.
- R5: On expiry the expiry flag (port `wd_flag` and status bit 7) is set and holds until the next write to address 0.
- R6: With the steering bit 0, expiry gives `irq_pulse` high for exactly one cycle, and `rst_req` stays low.
- R7: With the steering bit 1, expiry gives `rst_req` high for exactly one cycle, and `irq_pulse` stays low. In that same cycle the setting byte reads 0 and the auxiliary bit is cleared. No further expiry follows without a new setting.
- R8: A multiplier of 0 disables the watchdog: no tick causes an expiry.
- R9: A restart in the same cycle as the final tick wins: no expiry occurs, and the new count starts in full.
- R10: Address 2 holds a single auxiliary bit at bit position 6. Writes store only wdata bit 6, and reads return it at bit 6 with all other bits 0. Address 3 reads 0 and ignores writes.
- R11: After reset the setting byte, the flag and the auxiliary bit are 0, and `irq_pulse` and `rst_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_16hz | input | 1 | One-cycle enable, one per sixteenth of a second |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (a read of address 1 restarts the count) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| irq_pulse | output | 1 | One-cycle interrupt on expiry (steering bit 0) |
| rst_req | output | 1 | One-cycle reset request on expiry (steering bit 1) |
| wd_flag | output | 1 | Sticky expiry flag |

## Verification
Read data is combinational, so the bench samples it in the same cycle as the read strobe, before the clock edge that acts on the restart. Every expiry result (`irq_pulse`, `rst_req`, `wd_flag`, the cleared setting byte and auxiliary bit) is due one cycle after the clock edge that samples the final tick. The bench therefore drives each tick for one cycle from the falling edge and checks the outputs at the next falling edge. It confirms that the pulse has gone one cycle later, and it checks every tick before the final one for the absence of any expiry output.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned WD_DATA_W = 8;
  localparam int unsigned WD_RES_W  = 2;
  localparam int unsigned WD_MULT_W = 5;
  // largest shift is 2*(2^RES_W - 1)
  localparam int unsigned WD_CNT_W  = WD_MULT_W + 2 * ((1 << WD_RES_W) - 1);

  localparam int unsigned WD_STEER_BIT = WD_RES_W + WD_MULT_W;
  localparam int unsigned WD_FLAG_BIT  = 7;
  localparam int unsigned WD_AUX_BIT   = 6;

  localparam int unsigned WD_ADR_CFG   = 0;
  localparam int unsigned WD_ADR_FLAGS = 1;
  localparam int unsigned WD_ADR_AUX   = 2;

  typedef logic [WD_CNT_W-1:0]  wd_count_t;
  typedef logic [WD_DATA_W-1:0] wd_byte_t;

  // multiplier scaled by four to the power of the resolution
  function automatic wd_count_t wd_timeout(input wd_byte_t setting);
    logic [WD_MULT_W-1:0] mult;
    logic [WD_RES_W-1:0]  res;
    mult = setting[WD_RES_W +: WD_MULT_W];
    res  = setting[WD_RES_W-1:0];
    return wd_count_t'(mult) << (2 * res);
  endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  wd_byte_t          bus_wdata,
  input  logic              flag,
  input  logic              wipe,
  output wd_byte_t          cfg,
  output logic              aux,
  output logic              cfg_wr,
  output logic              reload,
  output wd_count_t         reload_val,
  output wd_byte_t          bus_rdata
);
  logic sel_cfg, sel_flags, sel_aux;
  logic flags_rd, aux_wr;

  assign sel_cfg   = (bus_addr == ADDR_W'(WD_ADR_CFG));
  assign sel_flags = (bus_addr == ADDR_W'(WD_ADR_FLAGS));
  assign sel_aux   = (bus_addr == ADDR_W'(WD_ADR_AUX));

  assign cfg_wr   = bus_wr && sel_cfg;
  assign aux_wr   = bus_wr && sel_aux;
  assign flags_rd = bus_rd && sel_flags;

  assign reload     = cfg_wr || flags_rd;
  assign reload_val = wd_timeout(cfg_wr ? bus_wdata : cfg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
      aux <= 1'b0;
    end else if (wipe) begin
      cfg <= '0;
      aux <= 1'b0;
    end else begin
      if (cfg_wr) cfg <= bus_wdata;
      if (aux_wr) aux <= bus_wdata[WD_AUX_BIT];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_cfg)   bus_rdata = cfg;
    if (sel_flags) bus_rdata[WD_FLAG_BIT] = flag;
    if (sel_aux)   bus_rdata[WD_AUX_BIT] = aux;
  end

  // R2: a written setting is held next cycle
  a_r2_cfg_stored: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> cfg == $past(bus_wdata));
  // R7: reset-steered expiry wipes setting and aux bit
  a_r7_wipe_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> (cfg == '0) && !aux);
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown
  import wdog_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      load,
  input  wd_count_t load_val,
  output wd_count_t count,
  output logic      expire
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    count <= '0;
    else if (load)                 count <= load_val;
    else if (tick && count != '0)  count <= count - 1'b1;
  end

  // restart wins over the final tick
  assign expire = tick && !load && (count == wd_count_t'(1));

  // R4: one step per tick
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && count != '0) |=> count == wd_count_t'($past(count) - 1'b1));
  // R8: an idle count stays idle until reloaded
  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && count == '0) |=> count == '0);
  // R9: a restart always loads the full value
  a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == $past(load_val));
endmodule

// File: rtl/wdog_action.sv
module wdog_action (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic steer,
  input  logic clear_flag,
  output logic flag,
  output logic irq_pulse,
  output logic rst_req,
  output logic wipe
);
  assign wipe = expire && steer;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag      <= 1'b0;
      irq_pulse <= 1'b0;
      rst_req   <= 1'b0;
    end else begin
      irq_pulse <= expire && !steer;
      rst_req   <= wipe;
      if (clear_flag)  flag <= 1'b0;
      else if (expire) flag <= 1'b1;
    end
  end

  // R5: expiry raises the flag
  a_r5_flag_on_expire: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag);
  // R2: setting write drops the flag
  a_r2_write_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
    clear_flag |=> !flag);
  // R6: interrupt lasts one cycle
  a_r6_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);
  // R7: reset request lasts one cycle
  a_r7_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  // R6: the two actions never overlap
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_pulse && rst_req));
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_16hz,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq_pulse,
  output logic              rst_req,
  output logic              wd_flag
);
  wd_byte_t  cfg;
  logic      aux;
  logic      cfg_wr, reload, expire, wipe;
  wd_count_t reload_val, count;

  wdog_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk, .rst_n, .bus_addr, .bus_wr, .bus_rd, .bus_wdata,
    .flag(wd_flag), .wipe, .cfg, .aux, .cfg_wr, .reload,
    .reload_val, .bus_rdata
  );

  wdog_countdown u_count (
    .clk, .rst_n, .tick(tick_16hz), .load(reload), .load_val(reload_val),
    .count, .expire
  );

  wdog_action u_action (
    .clk, .rst_n, .expire, .steer(cfg[WD_STEER_BIT]), .clear_flag(cfg_wr),
    .flag(wd_flag), .irq_pulse, .rst_req, .wipe
  );

  // R7: when the reset request is out, the setting is already wiped
  a_r7_rst_cfg_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (cfg == '0) && !aux && (count == '0));
  // R8: a zero multiplier never raises an action
  a_r8_no_action_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[WD_STEER_BIT-1:WD_RES_W] == '0 && !reload) |=> !irq_pulse && !rst_req);
endmodule

// File: tb/test_wdog_core.sv
module test_wdog_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq, rreq, flag;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  wdog_core i_wdog_core (
    .clk, .rst_n, .tick_16hz(tick), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_pulse(irq), .rst_req(rreq),
    .wd_flag(flag)
  );

  // {setting byte, expected ticks}
  localparam logic [18:0] VECS [0:5] = '{
    {8'h0C, 11'd3}, {8'h05, 11'd4}, {8'h0A, 11'd32},
    {8'h07, 11'd64}, {8'h7C, 11'd31}, {8'h15, 11'd20}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic one_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic quiet_ticks(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      one_tick();
      check(!irq && !rreq && !flag, req, {irq, rreq, flag}, 0);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(!irq && !rreq && !flag, "R11", {irq, rreq, flag}, 0);
    bus_read(2'd0, d); check(d == 8'h00, "R11 cfg", d, 0);
    bus_read(2'd2, d); check(d == 8'h00, "R11 aux", d, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R4 R5 R6: vector table of timeouts, interrupt steering
    foreach (VECS[k]) begin
      logic [7:0] c;
      int n;
      c = VECS[k][18:11];
      n = int'(VECS[k][10:0]);
      bus_write(2'd0, c);
      check(!flag, "R2 flag cleared", flag, 0);
      bus_read(2'd0, d); check(d == c, "R1 readback", d, c);
      quiet_ticks(n - 1, "R4 early");
      one_tick();
      check(irq && !rreq, "R6 irq on expiry", {irq, rreq}, 2);
      check(flag, "R5 flag set", flag, 1);
      @(negedge clk);
      check(!irq, "R6 single pulse", irq, 0);
      one_tick();
      check(!irq && flag, "R5 flag holds", {irq, flag}, 1);
    end
    bus_read(2'd1, d); check(d == 8'h80, "R3 status read", d, 8'h80);
    check(flag, "R3 read leaves flag", flag, 1);
    bus_write(2'd0, 8'h00);
    bus_read(2'd1, d); check(d == 8'h00, "R2 write clears flag", d, 0);

    // R8 zero multiplier, either steering
    quiet_ticks(100, "R8 disabled");
    bus_write(2'd0, 8'h83);
    quiet_ticks(100, "R8 disabled steered");

    // R3 status read restarts with stored setting
    bus_write(2'd0, 8'h10);
    quiet_ticks(2, "R3 pre");
    bus_read(2'd1, d);
    quiet_ticks(3, "R3 restarted");
    one_tick();
    check(irq && flag, "R3 expiry after restart", {irq, flag}, 3);

    // R9 restart on the final tick wins
    bus_write(2'd0, 8'h08);
    quiet_ticks(1, "R9 pre");
    @(negedge clk); tick = 1'b1; rd = 1'b1; addr = 2'd1;
    @(negedge clk); tick = 1'b0; rd = 1'b0;
    check(!irq && !flag, "R9 no expiry", {irq, flag}, 0);
    quiet_ticks(1, "R9 full count");
    one_tick();
    check(irq, "R9 later expiry", irq, 1);

    // R10 aux register and unused address
    bus_write(2'd2, 8'hFF);
    bus_read(2'd2, d); check(d == 8'h40, "R10 aux bit only", d, 8'h40);
    bus_write(2'd2, 8'hBF);
    bus_read(2'd2, d); check(d == 8'h00, "R10 aux clear", d, 0);
    bus_write(2'd3, 8'hFF);
    bus_read(2'd3, d); check(d == 8'h00, "R10 addr3", d, 0);
    bus_read(2'd0, d); check(d == 8'h08, "R10 addr3 write ignored", d, 8'h08);

    // R7 reset steering
    bus_write(2'd2, 8'h40);
    bus_write(2'd0, 8'h88);
    quiet_ticks(1, "R7 pre");
    one_tick();
    check(rreq && !irq, "R7 reset request", {rreq, irq}, 2);
    check(flag, "R7 flag set", flag, 1);
    @(negedge clk); addr = 2'd0; #1 d = rdata;
    check(!rreq, "R7 single pulse", rreq, 0);
    check(d == 8'h00, "R7 cfg wiped", d, 0);
    bus_read(2'd2, d); check(d == 8'h00, "R7 aux wiped", d, 0);
    for (int i = 0; i < 10; i++) begin
      one_tick();
      check(!rreq && !irq && flag, "R7 idle after", {rreq, irq, flag}, 1);
    end

    summary();
  end
endmodule